// File: doc/BRIEF.md
# Host Bridge Address Window Translator

This block sits between a processor core and a PCI host bridge and handles address translation in both directions. On the outbound side, each core address is sorted into one of four fixed regions: a 128 MB memory window, a 64 KB I/O window, a block of local configuration registers, and the single configuration data word. For the two windows, the bus address is formed by replacing the upper address bits with a prefix taken from a base register. The prefix is 5 bits for memory and 16 bits for I/O. A data port access puts the configuration address pointer on the bus. A register block access is flagged as a local hit. Any other address is flagged as an error and never reaches the bus.

On the inbound side, the block decides whether a transaction started by another bus master is claimed. Only memory cycles can be claimed. A cycle is claimed when its address falls in the on-chip L2 window or the system MMR window and the enable bit for that resource is set. I/O cycles are never claimed.

Both paths are registered once. Results appear one clock after the request. The prefix registers, the configuration pointer and the enable bits come in as plain inputs from the bridge's register file.

Top module: `hbx_addr_xlat`

## Requirements
- R1: A valid core address in 0xE0000000..0xE7FFFFFF gives, on the next cycle, ob_req=1, ob_region=1, and ob_addr = {ob_mem_base[31:27], core_addr[26:0]}. For example, base 0xE8000000 with core address 0xE7001234 gives 0xEF001234.
- R2: A valid core address in 0xEEFE0000..0xEEFEFFFF gives, on the next cycle, ob_req=1, ob_region=2, and ob_addr = {ob_io_base[31:16], core_addr[15:0]}.
- R3: A valid core address whose bits [31:2] match the word 0xEEFFFFFC gives, on the next cycle, ob_req=1, ob_region=4, ob_addr = cfg_ptr, and ob_cfg_t1 = cfg_ptr[0]. This region takes priority over the register block.
- R4: Any other valid core address in 0xEEFFFF00..0xEEFFFFFF gives, on the next cycle, ob_local=1, ob_region=3, ob_req=0, ob_err=0, and ob_addr=0.
- R5: A valid core address outside all four regions gives, on the next cycle, ob_err=1, ob_req=0, ob_local=0, ob_region=0, and ob_addr=0.
- R6: When core_valid=0, the next cycle shows ob_req=0, ob_local=0, ob_err=0, ob_region=0, ob_addr=0, and ob_cfg_t1=0. Whenever ob_req=0, ob_addr and ob_cfg_t1 are 0.
- R7: An inbound memory cycle whose address matches 0xF0000000..0xF003FFFF is claimed on the next cycle, with in_claim=1 and in_claim_sel=2'b01, only when host_en[0]=1. Otherwise both outputs are 0.
- R8: An inbound memory cycle whose address matches 0xFFC00000..0xFFFFFFFF is claimed on the next cycle, with in_claim=1 and in_claim_sel=2'b10, only when host_en[1]=1.
- R9: An inbound cycle with in_is_io=1 is never claimed, whatever its address and whatever the enable bits.
- R10: An inbound cycle outside both windows, or a cycle with in_valid=0, leaves in_claim=0 and in_claim_sel=0 on the next cycle.
- R11: While rst_n is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Outbound core request present |
| core_addr | input | 32 | Core-side address |
| ob_mem_base | input | 32 | Outbound memory base register; bits [31:27] are used |
| ob_io_base | input | 32 | Outbound I/O base register; bits [31:16] are used |
| cfg_ptr | input | 32 | Configuration address pointer; bit 0 selects type 1 |
| host_en | input | 2 | Inbound enables: bit 0 for L2, bit 1 for system MMR |
| in_valid | input | 1 | Inbound address phase present |
| in_addr | input | 32 | Inbound bus address |
| in_is_io | input | 1 | Inbound cycle is an I/O cycle |
| ob_req | output | 1 | Bus request for the translated address |
| ob_addr | output | 32 | Translated bus address |
| ob_region | output | 3 | Region code: 0 none, 1 memory, 2 I/O, 3 config registers, 4 config data |
| ob_local | output | 1 | Hit in the local configuration register block |
| ob_err | output | 1 | Address outside all regions |
| ob_cfg_t1 | output | 1 | Configuration data access is type 1 |
| in_claim | output | 1 | Inbound cycle claimed |
| in_claim_sel | output | 2 | One-hot claimed resource: bit 0 L2, bit 1 MMR |

## Verification
The outbound translation and the inbound claim decision are independent, and both can produce a result in the same clock cycle. The bench provokes this by driving a fresh core request and a fresh inbound address phase together on every cycle. The addresses are drawn at random, with a bias toward each window and toward the addresses just inside and just outside every boundary, and the prefixes, pointer and enables are randomized as well. Each cycle, both result sets are judged against bench functions computed from the input values of the previous cycle. This confirms that activity on one path never disturbs the other.

// File: rtl/hbx_pkg.sv
// Shared definitions for the host bridge address translator.
// Assumes a 32-bit core and bus address space.
package hbx_pkg;
    localparam int AW = 32;

    // Outbound region codes as seen on ob_region.
    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_MEM     = 3'd1,
        RGN_IO      = 3'd2,
        RGN_CFGREG  = 3'd3,
        RGN_CFGDATA = 3'd4
    } ob_region_e;
endpackage

// File: rtl/hbx_win_match.sv
// Window comparator: reports whether an address falls inside an aligned
// power-of-two window given by its base and the number of offset bits.
// Assumes BASE is aligned to 2**SPAN_W and SPAN_W < AW.
module hbx_win_match #(
    parameter int              AW     = 32,
    parameter logic [AW-1:0]   BASE   = '0,
    parameter int              SPAN_W = 16
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW-SPAN_W-1:0] TAG = BASE[AW-1:SPAN_W];

    // Compare the bits above the window offset with the base tag.
    always_comb begin
        hit = (addr[AW-1:SPAN_W] == TAG);
    end
endmodule

// File: rtl/hbx_out_path.sv
// Outbound path: sorts a core address into a region and builds the bus
// address by splicing a base prefix onto the offset bits, one register stage.
// Assumes the memory, I/O and register-block windows do not overlap; the
// data port word lies inside the register block and takes priority over it.
module hbx_out_path
    import hbx_pkg::*;
#(
    parameter logic [AW-1:0] MEM_BASE  = 32'hE000_0000,
    parameter int            MEM_SPAN_W = 27,
    parameter logic [AW-1:0] IO_BASE   = 32'hEEFE_0000,
    parameter int            IO_SPAN_W = 16,
    parameter logic [AW-1:0] REG_BASE  = 32'hEEFF_FF00,
    parameter int            REG_SPAN_W = 8,
    parameter logic [AW-1:0] PORT_ADDR = 32'hEEFF_FFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_valid,
    input  logic [AW-1:0] core_addr,
    input  logic [AW-1:0] ob_mem_base,
    input  logic [AW-1:0] ob_io_base,
    input  logic [AW-1:0] cfg_ptr,
    output logic          ob_req,
    output logic [AW-1:0] ob_addr,
    output logic [2:0]    ob_region,
    output logic          ob_local,
    output logic          ob_err,
    output logic          ob_cfg_t1
);
    localparam int PORT_SPAN_W = 2;

    logic          hit_mem, hit_io, hit_reg, hit_port;
    ob_region_e    rgn_d;
    logic [AW-1:0] addr_d;
    logic          req_d, local_d, err_d, t1_d;

    hbx_win_match #(.AW(AW), .BASE(MEM_BASE), .SPAN_W(MEM_SPAN_W)) u_mem (
        .addr(core_addr), .hit(hit_mem));
    hbx_win_match #(.AW(AW), .BASE(IO_BASE), .SPAN_W(IO_SPAN_W)) u_io (
        .addr(core_addr), .hit(hit_io));
    hbx_win_match #(.AW(AW), .BASE(REG_BASE), .SPAN_W(REG_SPAN_W)) u_reg (
        .addr(core_addr), .hit(hit_reg));
    hbx_win_match #(.AW(AW), .BASE(PORT_ADDR), .SPAN_W(PORT_SPAN_W)) u_port (
        .addr(core_addr), .hit(hit_port));

    // Priority region select: data port, register block, I/O, memory.
    always_comb begin
        if (!core_valid)   rgn_d = RGN_NONE;
        else if (hit_port) rgn_d = RGN_CFGDATA;
        else if (hit_reg)  rgn_d = RGN_CFGREG;
        else if (hit_io)   rgn_d = RGN_IO;
        else if (hit_mem)  rgn_d = RGN_MEM;
        else               rgn_d = RGN_NONE;
    end

    // Build the bus address and the per-region flags.
    always_comb begin
        addr_d  = '0;
        req_d   = 1'b0;
        local_d = 1'b0;
        err_d   = 1'b0;
        t1_d    = 1'b0;
        case (rgn_d)
            RGN_MEM: begin
                req_d  = 1'b1;
                addr_d = {ob_mem_base[AW-1:MEM_SPAN_W], core_addr[MEM_SPAN_W-1:0]};
            end
            RGN_IO: begin
                req_d  = 1'b1;
                addr_d = {ob_io_base[AW-1:IO_SPAN_W], core_addr[IO_SPAN_W-1:0]};
            end
            RGN_CFGDATA: begin
                req_d  = 1'b1;
                addr_d = cfg_ptr;
                t1_d   = cfg_ptr[0];
            end
            RGN_CFGREG: local_d = 1'b1;
            default:    err_d   = core_valid;
        endcase
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_req    <= 1'b0;
            ob_addr   <= '0;
            ob_region <= RGN_NONE;
            ob_local  <= 1'b0;
            ob_err    <= 1'b0;
            ob_cfg_t1 <= 1'b0;
        end else begin
            ob_req    <= req_d;
            ob_addr   <= addr_d;
            ob_region <= rgn_d;
            ob_local  <= local_d;
            ob_err    <= err_d;
            ob_cfg_t1 <= t1_d;
        end
    end

    AST_ERR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ob_err |-> (!ob_req && !ob_local)); // R5
    AST_MEM_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && hit_mem) |=> (ob_req && ob_addr[MEM_SPAN_W-1:0] == $past(core_addr[MEM_SPAN_W-1:0]))); // R1
    AST_IO_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && hit_io) |=> (ob_req && ob_addr[IO_SPAN_W-1:0] == $past(core_addr[IO_SPAN_W-1:0]))); // R2
    AST_PORT_USES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && hit_port) |=> (ob_req && ob_addr == $past(cfg_ptr))); // R3
    AST_LOCAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ob_req, ob_local, ob_err})); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !core_valid |=> (!ob_req && !ob_local && !ob_err)); // R6
endmodule

// File: rtl/hbx_in_path.sv
// Inbound path: decides whether a memory cycle from another bus master is
// claimed. Each resource window is matched and gated by its own enable bit;
// I/O cycles are never claimed. The claim is registered with the address phase.
// Assumes the resource windows are disjoint.
module hbx_in_path
    import hbx_pkg::*;
#(
    parameter int                      NWIN     = 2,
    parameter logic [NWIN-1:0][AW-1:0] WIN_BASE = {32'hFFC0_0000, 32'hF000_0000},
    parameter logic [NWIN-1:0][7:0]    WIN_SPAN = {8'd22, 8'd18}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [AW-1:0]   in_addr,
    input  logic            in_is_io,
    input  logic [NWIN-1:0] host_en,
    output logic            in_claim,
    output logic [NWIN-1:0] in_claim_sel
);
    logic [NWIN-1:0] win_hit;
    logic [NWIN-1:0] sel_d;
    logic            mem_cycle;

    // One comparator per resource window.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int SW = int'(WIN_SPAN[g]);
        hbx_win_match #(.AW(AW), .BASE(WIN_BASE[g]), .SPAN_W(SW)) u_match (
            .addr(in_addr), .hit(win_hit[g]));
    end

    // Only memory cycles are candidates; gate hits by enables.
    always_comb begin
        mem_cycle = in_valid && !in_is_io;
        sel_d     = mem_cycle ? (win_hit & host_en) : '0;
    end

    // Register the claim together with the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_claim     <= 1'b0;
            in_claim_sel <= '0;
        end else begin
            in_claim     <= |sel_d;
            in_claim_sel <= sel_d;
        end
    end

    AST_IO_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_io) |=> !in_claim); // R9
    AST_CLAIM_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_claim_sel)); // R7
    AST_CLAIM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_claim |-> ((in_claim_sel & $past(host_en)) != '0)); // R8
    AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!in_claim && in_claim_sel == '0)); // R10
endmodule

// File: rtl/hbx_addr_xlat.sv
// Top level of the host bridge address translator. Joins the outbound
// region decode and prefix splice with the inbound claim gate. Register
// values (prefixes, pointer, enables) arrive as inputs from the register file.
module hbx_addr_xlat
    import hbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_valid,
    input  logic [31:0] core_addr,
    input  logic [31:0] ob_mem_base,
    input  logic [31:0] ob_io_base,
    input  logic [31:0] cfg_ptr,
    input  logic [1:0]  host_en,
    input  logic        in_valid,
    input  logic [31:0] in_addr,
    input  logic        in_is_io,
    output logic        ob_req,
    output logic [31:0] ob_addr,
    output logic [2:0]  ob_region,
    output logic        ob_local,
    output logic        ob_err,
    output logic        ob_cfg_t1,
    output logic        in_claim,
    output logic [1:0]  in_claim_sel
);
    hbx_out_path u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_valid (core_valid),
        .core_addr  (core_addr),
        .ob_mem_base(ob_mem_base),
        .ob_io_base (ob_io_base),
        .cfg_ptr    (cfg_ptr),
        .ob_req     (ob_req),
        .ob_addr    (ob_addr),
        .ob_region  (ob_region),
        .ob_local   (ob_local),
        .ob_err     (ob_err),
        .ob_cfg_t1  (ob_cfg_t1)
    );

    hbx_in_path #(.NWIN(2)) u_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_is_io    (in_is_io),
        .host_en     (host_en),
        .in_claim    (in_claim),
        .in_claim_sel(in_claim_sel)
    );

    // Reset clears every output on the following edge.
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!ob_req && !ob_err && !ob_local && !in_claim)); // R11
endmodule

// File: tb/tb_hbx_addr_xlat.sv
module tb_hbx_addr_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_valid = 1'b0;
    logic [31:0] core_addr = '0, ob_mem_base = '0, ob_io_base = '0, cfg_ptr = '0;
    logic [1:0]  host_en = '0;
    logic        in_valid = 1'b0, in_is_io = 1'b0;
    logic [31:0] in_addr = '0;
    logic        ob_req, ob_local, ob_err, ob_cfg_t1, in_claim;
    logic [31:0] ob_addr;
    logic [2:0]  ob_region;
    logic [1:0]  in_claim_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hbx_addr_xlat dut (.*);

    // Expected outbound result: {req, local, err, t1, region[2:0], addr[31:0]}
    function automatic logic [38:0] exp_ob(input logic v, input logic [31:0] a,
        input logic [31:0] mb, input logic [31:0] ib, input logic [31:0] cp);
        if (!v)                         return '0;
        if (a[31:2] == 30'h3BBF_FFFF)   return {1'b1, 1'b0, 1'b0, cp[0], 3'd4, cp};
        if (a[31:8] == 24'hEEFFFF)      return {1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0};
        if (a[31:16] == 16'hEEFE)       return {1'b1, 1'b0, 1'b0, 1'b0, 3'd2, ib[31:16], a[15:0]};
        if (a[31:27] == 5'b11100)       return {1'b1, 1'b0, 1'b0, 1'b0, 3'd1, mb[31:27], a[26:0]};
        return {1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0};
    endfunction

    function automatic string ob_tag(input logic v, input logic [31:0] a);
        if (!v)                       return "R6";
        if (a[31:2] == 30'h3BBF_FFFF) return "R3";
        if (a[31:8] == 24'hEEFFFF)    return "R4";
        if (a[31:16] == 16'hEEFE)     return "R2";
        if (a[31:27] == 5'b11100)     return "R1";
        return "R5";
    endfunction

    // Expected inbound result: {claim, sel[1:0]}
    function automatic logic [2:0] exp_in(input logic v, input logic [31:0] a,
        input logic io, input logic [1:0] en);
        logic [1:0] s;
        if (!v || io) return '0;
        s = {(a[31:22] == 10'h3FF) & en[1], (a[31:18] == 14'h3C00) & en[0]};
        return {|s, s};
    endfunction

    function automatic string in_tag(input logic v, input logic [31:0] a, input logic io);
        if (v && io)                 return "R9";
        if (!v)                      return "R10";
        if (a[31:18] == 14'h3C00)    return "R7";
        if (a[31:22] == 10'h3FF)     return "R8";
        return "R10";
    endfunction

    // Drive one cycle on both paths, then judge both results after the edge.
    task automatic cyc(input logic v, input logic [31:0] a, input logic [31:0] mb,
        input logic [31:0] ib, input logic [31:0] cp, input logic iv,
        input logic [31:0] ia, input logic iio, input logic [1:0] en);
        logic [38:0] eo, ao;
        logic [2:0]  ei, ai;
        core_valid = v; core_addr = a; ob_mem_base = mb; ob_io_base = ib;
        cfg_ptr = cp; in_valid = iv; in_addr = ia; in_is_io = iio; host_en = en;
        eo = exp_ob(v, a, mb, ib, cp);
        ei = exp_in(iv, ia, iio, en);
        @(posedge clk);
        @(negedge clk);
        ao = {ob_req, ob_local, ob_err, ob_cfg_t1, ob_region, ob_addr};
        ai = {in_claim, in_claim_sel};
        checks++;
        if (ao !== eo) begin
            fails++;
            $display("FAIL %s outbound addr=%h actual=%h expected=%h", ob_tag(v, a), a, ao, eo);
        end
        checks++;
        if (ai !== ei) begin
            fails++;
            $display("FAIL %s inbound addr=%h io=%0b en=%b actual=%b expected=%b",
                     in_tag(iv, ia, iio), ia, iio, en, ai, ei);
        end
    endtask

    function automatic logic [31:0] pick_core();
        case ($urandom_range(0, 7))
            0: return {5'b11100, 27'($urandom)};
            1: return {16'hEEFE, 16'($urandom)};
            2: return {24'hEEFFFF, 8'($urandom)};
            3: return 32'hEEFF_FFFC | 32'($urandom_range(0, 3));
            4: begin
                logic [31:0] e[8] = '{32'hE7FF_FFFF, 32'hE800_0000, 32'hDFFF_FFFF,
                    32'hEEFD_FFFF, 32'hEEFF_0000, 32'hEEFF_FEFF, 32'hEEFF_FFFB, 32'hEEFF_FF00};
                return e[$urandom_range(0, 7)];
            end
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [31:0] pick_in();
        case ($urandom_range(0, 5))
            0: return {14'h3C00, 18'($urandom)};
            1: return {10'h3FF, 22'($urandom)};
            2: begin
                logic [31:0] e[4] = '{32'hF004_0000, 32'hEFFF_FFFF, 32'hFFBF_FFFF, 32'hF003_FFFF};
                return e[$urandom_range(0, 3)];
            end
            default: return $urandom;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R11: reset clears outputs even with requests pending.
        core_valid = 1'b1; core_addr = 32'hE000_0010; in_valid = 1'b1;
        in_addr = 32'hF000_0000; host_en = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({ob_req, ob_local, ob_err, ob_cfg_t1, ob_region, ob_addr, in_claim, in_claim_sel} !== '0) begin
            fails++;
            $display("FAIL R11 reset outputs actual=%b%b%b expected=000", ob_req, ob_err, in_claim);
        end
        rst_n = 1'b1;

        // Directed corner cases.
        cyc(1, 32'hE700_1234, 32'hE800_0000, 0, 0, 1, 32'hF000_0004, 0, 2'b01); // R1, R7
        cyc(1, 32'hE700_1234, 32'hE000_0000, 0, 0, 1, 32'hF000_0004, 0, 2'b10); // R1, R7 disabled
        cyc(1, 32'hEEFE_ABCD, 0, 32'h1234_0000, 0, 1, 32'hFFC0_0100, 0, 2'b10); // R2, R8
        cyc(1, 32'hEEFF_FFFC, 0, 0, 32'h0001_0A01, 1, 32'hFFC0_0100, 0, 2'b01); // R3 type 1, R8 disabled
        cyc(1, 32'hEEFF_FFFE, 0, 0, 32'h0000_0810, 1, 32'hF000_0000, 1, 2'b11); // R3 type 0, R9
        cyc(1, 32'hEEFF_FF40, 0, 0, 32'hFFFF_FFFF, 1, 32'hFFC0_0000, 1, 2'b11); // R4, R9
        cyc(1, 32'hE800_0000, 32'hF800_0000, 0, 0, 1, 32'hF004_0000, 0, 2'b11); // R5, R10
        cyc(0, 32'hE000_0000, 32'hF800_0000, 0, 32'h5, 0, 32'hF000_0000, 0, 2'b11); // R6, R10

        // Random mix, both paths active in the same cycle.
        for (int i = 0; i < 3000; i++) begin
            cyc($urandom_range(0, 9) != 0, pick_core(), $urandom, $urandom, $urandom,
                $urandom_range(0, 9) != 0, pick_in(), $urandom_range(0, 4) == 0,
                2'($urandom));
        end

        // R11: reset in mid-run clears a pending claim and request.
        core_valid = 1'b1; core_addr = 32'hE000_0000; in_valid = 1'b1;
        in_is_io = 1'b0; in_addr = 32'hF000_0000; host_en = 2'b11;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (ob_req !== 1'b0 || in_claim !== 1'b0) begin
            fails++;
            $display("FAIL R11 mid-run reset actual=%b%b expected=00", ob_req, in_claim);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule